// File: doc/BRIEF.md
# Shared-Memory Command Ring Reader

This block is the consumer side of a command queue that a host writes into shared memory. The queue is a ring of 32-bit words. A four-word header at word addresses 0 to 3 holds the ring bounds and the two pointers as byte offsets. The host appends words and moves the write pointer. The reader fetches the word at the read pointer and passes it to a command decoder over a valid/ready stream. It then moves the read pointer forward, wraps it at the upper bound and writes it back to the header. The memory port is a plain synchronous word port. A read issued in one cycle returns its data in the next cycle.

The host enables the reader with a configuration-done level. While that level is low, the reader makes no memory access. Each time it is enabled, it reloads the whole header. A one-cycle sync pulse raises a busy flag. The flag stays high until the reader sees the ring empty. The reader tracks command boundaries with a small opcode-length table. A word at a command boundary that is not a known opcode stops the reader for good and raises a sticky error.

The controller has ten states. `ST_IDLE` waits for enable and goes to `ST_HDR_REQ`. `ST_HDR_REQ` and `ST_HDR_CAP` alternate four times to load the header, then move to `ST_POLL_REQ`. `ST_POLL_REQ` goes to `ST_POLL_CAP`, or back to `ST_IDLE` when disabled. `ST_POLL_CAP` returns to `ST_POLL_REQ` if the ring is empty and goes to `ST_FETCH_REQ` otherwise. `ST_FETCH_REQ` goes to `ST_FETCH_CAP`, or to `ST_IDLE` when disabled. `ST_FETCH_CAP` goes to `ST_OFFER`, or to `ST_HALT` on a bad opcode. `ST_OFFER` waits for ready and then goes to `ST_WBACK`. `ST_WBACK` goes to `ST_FETCH_REQ` if more words are known and to `ST_POLL_REQ` otherwise. `ST_HALT` is terminal until reset.

Top module: `ring_cmd_reader`

## Requirements
- R1: Header words are at word addresses 0 (lower bound), 1 (upper bound), 2 (write pointer) and 3 (read pointer). Each holds a byte offset, and the reader turns it into a word address by dropping its two low bits.
- R2: While cfg_done is 0 in the idle state, mem_req stays 0 and no word is presented. When cfg_done becomes 1, the header is loaded from memory before any ring word is fetched.
- R3: After cfg_done falls, the reader finishes at most the word it is already presenting and then makes no further memory request. When it is enabled again, it reloads the header.
- R4: The ring is empty when the write pointer equals the read pointer. While the ring is empty, no word is presented and the write pointer is re-read from memory again and again, so words the host appends later are picked up.
- R5: Ring words are presented in ring order starting at the read pointer. cmd_data is held stable while cmd_valid is 1 and cmd_ready is 0.
- R6: After each accepted word, the read pointer moves forward one word. It is written to word address 3 as a byte offset, so after a drain word 3 equals word 2.
- R7: A word index that reaches the upper bound wraps to the lower bound.
- R8: A one-cycle sync_req pulse makes busy read 1 from the next cycle on. busy returns to 0 only once the reader finds the ring empty, which means every queued word has been accepted.
- R9: cmd_first is 1 on the opcode word of each command. Command lengths, counting the opcode word, are: opcode 1 is 5 words, opcode 2 is 6 words, opcode 3 is 7 words.
- R10: A word at a command boundary whose value is not 1, 2 or 3 is not presented, and the read pointer is not moved past it. err becomes 1 and stays 1, and no memory request follows until reset.
- R11: After reset, cmd_valid, mem_req, busy and err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Host enable level for the reader |
| sync_req | input | 1 | One-cycle sync request pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | 32 | Write data (read pointer as a byte offset) |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cmd_valid | output | 1 | A ring word is being presented |
| cmd_ready | input | 1 | The decoder accepts the presented word |
| cmd_data | output | 32 | The presented ring word |
| cmd_first | output | 1 | The presented word is an opcode |
| busy | output | 1 | A sync request is still pending |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
Commands of all three lengths are streamed three ways: with the decoder always ready, with a periodic ready pattern, and with a full stall. Comparing these separates word ordering from hold behaviour under backpressure. A small ten-word ring is filled past its end, so the wrap and the host's full wait both happen, which a large ring would never reach. Sync is tried both with words stuck behind a stalled decoder and on an empty ring. The first case shows that busy tracks the drain; the second shows that busy clears without any consumed word. Disabling the reader mid-command, polling an empty ring, and a bad opcode at a boundary each have their own window. In each window the memory requests and the written-back read pointer are counted.

// File: rtl/ring_rd_pkg.sv
package ring_rd_pkg;

    localparam int WORD_W        = 32;
    localparam int MAX_CMD_WORDS = 7;
    localparam int LEN_W         = $clog2(MAX_CMD_WORDS + 1);

    localparam logic [1:0] HDR_MIN  = 2'd0;
    localparam logic [1:0] HDR_MAX  = 2'd1;
    localparam logic [1:0] HDR_NEXT = 2'd2;
    localparam logic [1:0] HDR_STOP = 2'd3;

    localparam logic [WORD_W-1:0] OP_UPDATE = 32'd1;
    localparam logic [WORD_W-1:0] OP_FILL   = 32'd2;
    localparam logic [WORD_W-1:0] OP_COPY   = 32'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_CAP,
        ST_POLL_REQ,
        ST_POLL_CAP,
        ST_FETCH_REQ,
        ST_FETCH_CAP,
        ST_OFFER,
        ST_WBACK,
        ST_HALT
    } rd_state_e;

    // Total words of a command including its opcode; 0 means unknown opcode.
    function automatic logic [LEN_W-1:0] op_words(input logic [WORD_W-1:0] op);
        case (op)
            OP_UPDATE: op_words = LEN_W'(5);
            OP_FILL:   op_words = LEN_W'(6);
            OP_COPY:   op_words = LEN_W'(7);
            default:   op_words = '0;
        endcase
    endfunction

endpackage

// File: rtl/ring_step.sv
module ring_step #(
    parameter int W = 14
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt
);
    logic [W-1:0] inc;

    always_comb begin
        inc = cur + W'(1);
        nxt = (inc == hi) ? lo : inc;
    end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import ring_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [WORD_W-1:0] cand_word,
    output logic              at_start,
    output logic              bad_op
);
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            left_q <= '0;
        end else if (acc) begin
            if (left_q == '0) left_q <= op_words(acc_word) - LEN_W'(1);
            else              left_q <= left_q - LEN_W'(1);
        end
    end

    always_comb begin
        at_start = (left_q == '0);
        bad_op   = at_start && (op_words(cand_word) == '0);
    end

    // R9
    left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= LEN_W'(MAX_CMD_WORDS - 1));

    // R10
    known_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_start) |-> (op_words(acc_word) != '0));

endmodule

// File: rtl/sync_tracker.sv
module sync_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    input  logic drained,
    output logic busy
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (sync_req) busy_q <= 1'b1;
        else if (drained)  busy_q <= 1'b0;
    end

    assign busy = busy_q;

    // R8
    sync_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> busy);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drained && !sync_req) |=> busy);

endmodule

// File: rtl/ring_cmd_reader.sv
module ring_cmd_reader
    import ring_rd_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              sync_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_data,
    output logic              cmd_first,
    output logic              busy,
    output logic              err
);
    localparam int PAD_W = WORD_W - ADDR_W - 2;

    rd_state_e         state_q, state_d;
    logic [1:0]        hdr_sel;
    logic [ADDR_W-1:0] min_idx, max_idx, next_idx, stop_idx, stop_nxt, rd_idx;
    logic [WORD_W-1:0] word_q;
    logic              err_q;
    logic              at_start, bad_op, accept, drained;

    assign rd_idx  = mem_rdata[ADDR_W+1:2];
    assign accept  = (state_q == ST_OFFER) && cmd_ready;
    assign drained = (state_q == ST_POLL_CAP) && (rd_idx == stop_idx);

    ring_step #(.W(ADDR_W)) u_step (
        .cur (stop_idx),
        .lo  (min_idx),
        .hi  (max_idx),
        .nxt (stop_nxt)
    );

    cmd_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_IDLE),
        .acc       (accept),
        .acc_word  (word_q),
        .cand_word (mem_rdata),
        .at_start  (at_start),
        .bad_op    (bad_op)
    );

    sync_tracker u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .drained  (drained),
        .busy     (busy)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cfg_done) state_d = ST_HDR_REQ;
            ST_HDR_REQ:   state_d = ST_HDR_CAP;
            ST_HDR_CAP:   state_d = (hdr_sel == HDR_STOP) ? ST_POLL_REQ : ST_HDR_REQ;
            ST_POLL_REQ:  state_d = cfg_done ? ST_POLL_CAP : ST_IDLE;
            ST_POLL_CAP:  state_d = (rd_idx == stop_idx) ? ST_POLL_REQ : ST_FETCH_REQ;
            ST_FETCH_REQ: state_d = cfg_done ? ST_FETCH_CAP : ST_IDLE;
            ST_FETCH_CAP: state_d = bad_op ? ST_HALT : ST_OFFER;
            ST_OFFER:     if (cmd_ready) state_d = ST_WBACK;
            ST_WBACK:     state_d = (stop_idx == next_idx) ? ST_POLL_REQ : ST_FETCH_REQ;
            ST_HALT:      state_d = ST_HALT;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_sel  <= HDR_MIN;
            min_idx  <= '0;
            max_idx  <= '0;
            next_idx <= '0;
            stop_idx <= '0;
            word_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: hdr_sel <= HDR_MIN;
                ST_HDR_CAP: begin
                    unique case (hdr_sel)
                        HDR_MIN:  min_idx  <= rd_idx;
                        HDR_MAX:  max_idx  <= rd_idx;
                        HDR_NEXT: next_idx <= rd_idx;
                        HDR_STOP: stop_idx <= rd_idx;
                        default:  ;
                    endcase
                    hdr_sel <= hdr_sel + 2'd1;
                end
                ST_POLL_CAP:  next_idx <= rd_idx;
                ST_FETCH_CAP: begin
                    word_q <= mem_rdata;
                    if (bad_op) err_q <= 1'b1;
                end
                ST_OFFER: if (cmd_ready) stop_idx <= stop_nxt;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = {{PAD_W{1'b0}}, stop_idx, 2'b00};
        unique case (state_q)
            ST_HDR_REQ: begin
                mem_req  = 1'b1;
                mem_addr = ADDR_W'(hdr_sel);
            end
            ST_POLL_REQ: begin
                mem_req  = cfg_done;
                mem_addr = ADDR_W'(HDR_NEXT);
            end
            ST_FETCH_REQ: begin
                mem_req  = cfg_done;
                mem_addr = stop_idx;
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ADDR_W'(HDR_STOP);
            end
            default: ;
        endcase
        cmd_valid = (state_q == ST_OFFER);
        cmd_data  = word_q;
        cmd_first = (state_q == ST_OFFER) && at_start;
        err       = err_q;
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!mem_req && !cmd_valid));

    // R5
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R6
    wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == ADDR_W'(HDR_STOP)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10
    err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !cmd_valid));

endmodule

// File: tb/ring_cmd_reader_tb_top.sv
module ring_cmd_reader_tb_top;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n, cfg_done, sync_req, cmd_ready;
    logic          mem_req, mem_we, cmd_valid, cmd_first, busy, err;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata, cmd_data;

    always #5 clk = ~clk;

    ring_cmd_reader #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .sync_req(sync_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_first(cmd_first), .busy(busy), .err(err)
    );

    logic [31:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    int n_cmp = 0, n_bad = 0, acc_cnt = 0, req_cnt = 0, cyc = 0, ready_mode = 0;
    int ring_min, ring_max, prod_next;
    bit done = 1'b0;
    logic [32:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (mem_req) req_cnt++;
        if (cmd_valid && cmd_ready) begin
            acc_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected word", cmd_data, 32'hx);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                chk(cmd_data == e[31:0], "R5 word order", cmd_data, e[31:0]);
                chk(cmd_first == e[32], "R9 opcode marker", {31'd0, cmd_first}, {31'd0, e[32]});
            end
        end
    end

    // Ready driver
    initial begin
        cmd_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            case (ready_mode)
                0: cmd_ready = 1'b1;
                1: cmd_ready = (cyc % 3) != 0;
                default: cmd_ready = 1'b0;
            endcase
        end
    end

    function automatic int step_idx(input int i);
        return (i + 1 == ring_max) ? ring_min : i + 1;
    endfunction

    task automatic publish();
        mem[2] = prod_next * 4;
    endtask

    task automatic put_word(input logic [31:0] w, input bit first);
        if (step_idx(prod_next) == int'(mem[3] >> 2)) begin
            publish();
            while (step_idx(prod_next) == int'(mem[3] >> 2)) @(posedge clk);
        end
        mem[prod_next] = w;
        exp_q.push_back({first, w});
        prod_next = step_idx(prod_next);
    endtask

    task automatic put_cmd(input logic [31:0] op, input int args, input logic [31:0] seed);
        put_word(op, 1'b1);
        for (int i = 0; i < args; i++) put_word(seed + i, 1'b0);
        publish();
    endtask

    task automatic setup_ring(input int min_b, input int max_b);
        cfg_done = 1'b0;
        repeat (6) @(posedge clk);
        ring_min = min_b / 4; ring_max = max_b / 4; prod_next = ring_min;
        mem[0] = min_b; mem[1] = max_b; mem[2] = min_b; mem[3] = min_b;
        exp_q.delete();
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 8000) begin @(posedge clk); t++; end
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        chk(mem[3] == mem[2], "R6 stop written back", mem[3], mem[2]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r0, a0, bad_at;
        rst_n = 1'b0; cfg_done = 1'b0; sync_req = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk({cmd_valid, mem_req, busy, err} == 4'b0, "R11 reset outputs",
            {28'd0, cmd_valid, mem_req, busy, err}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: disabled reader does nothing
        setup_ring(16, 16 + 10240);
        put_cmd(32'd1, 4, 32'hA000);
        r0 = req_cnt; a0 = acc_cnt;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(req_cnt == r0, "R2 no request while disabled", req_cnt - r0, 0);
        chk(acc_cnt == a0, "R2 no word while disabled", acc_cnt - a0, 0);
        cfg_done = 1'b1;
        wait_drain("R1 header load then drain");

        // R5/R9: all lengths with periodic backpressure
        ready_mode = 1;
        put_cmd(32'd2, 5, 32'hB000);
        put_cmd(32'd3, 6, 32'hC000);
        put_cmd(32'd1, 4, 32'hD000);
        wait_drain("R9 mixed lengths drained");

        // R8: sync with stalled decoder
        ready_mode = 2;
        put_cmd(32'd3, 6, 32'hE000);
        repeat (8) @(posedge clk);
        #1 sync_req = 1'b1; @(posedge clk); #1 sync_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after sync", busy, 1);
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy held while words pending", busy, 1);
        ready_mode = 0;
        begin
            int t = 0;
            while (busy && t < 2000) begin @(negedge clk); t++; end
        end
        chk(exp_q.size() == 0, "R8 busy falls only after drain", exp_q.size(), 0);
        chk(busy == 1'b0, "R8 busy returns to 0", busy, 0);

        // R8: sync on empty ring
        @(posedge clk); #1 sync_req = 1'b1; @(posedge clk); #1 sync_req = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy raised on empty ring", busy, 1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy clears on empty ring", busy, 0);

        // R4: polling an empty ring
        r0 = req_cnt; a0 = acc_cnt;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(acc_cnt == a0, "R4 nothing presented when empty", acc_cnt - a0, 0);
        chk(req_cnt > r0 + 5, "R4 pointer re-read while empty", req_cnt - r0, 6);
        put_cmd(32'd2, 5, 32'hF000);
        wait_drain("R4 late words picked up");

        // R3: disable mid-command
        ready_mode = 2;
        put_cmd(32'd1, 4, 32'h1100);
        repeat (10) @(posedge clk);
        #1 cfg_done = 1'b0;
        ready_mode = 0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 4, "R3 only word in flight finished", exp_q.size(), 4);
        r0 = req_cnt;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(req_cnt == r0, "R3 no request after disable", req_cnt - r0, 0);

        // R7: small ring of ten words, wrapped several times
        setup_ring(16, 16 + 40);
        cfg_done = 1'b1;
        ready_mode = 1;
        for (int k = 0; k < 6; k++) put_cmd(32'd1 + (k % 3), 4 + (k % 3), 32'h2000 + k * 16);
        wait_drain("R7 wrapped ring drained");
        chk(mem[3] >= 16 && mem[3] < 56, "R7 pointer inside bounds", mem[3], 16);
        chk(mem[3][1:0] == 2'b00, "R1 pointer is a word-aligned byte offset", mem[3], 0);

        // R10: unknown opcode
        bad_at = prod_next;
        mem[prod_next] = 32'h55;
        prod_next = step_idx(prod_next);
        publish();
        a0 = acc_cnt;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(err == 1'b1, "R10 error raised", err, 1);
        chk(acc_cnt == a0, "R10 bad word not presented", acc_cnt - a0, 0);
        chk(mem[3] == bad_at * 4, "R10 pointer not advanced", mem[3], bad_at * 4);
        r0 = req_cnt;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(req_cnt == r0, "R10 no request after error", req_cnt - r0, 0);
        chk(err == 1'b1, "R10 error sticky", err, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule